// File: doc/BRIEF.md
# Multi-VC Credit Link

This block models one link of an on-chip network that carries several virtual channels, with credit-based flow control on each channel. The sending side keeps a credit counter for every virtual channel of the receiver. Each counter starts at the receiver's per-channel buffer depth. A flit tagged with a channel id is accepted only while that channel still has credit, and each accepted flit uses up one credit. The receiving side stores flits in one FIFO per channel. When a consumer dequeues a flit, a credit tagged with the same channel goes back to the sender through a delay line of configurable length, which stands in for the return wire and its pipeline.

The block is used to size receiver buffers against the credit round trip. When the sender issues a flit in every cycle it is allowed to, a channel with a shallow buffer stalls while it waits for returned credits. A channel whose depth covers the round trip runs at full rate. Credit returns and new sends may land on the same channel in the same cycle, and the count stays exact when they do.

Top module: `vc_credit_link`

## Requirements
- R1: After a synchronous reset, `can_send` is all ones and `vc_ready`, `out_valid` and `crd_valid` are all zero.
- R2: A send is accepted when `snd_valid` is high and `can_send[snd_vc]` is high, and it uses one credit. After BUF_DEPTH accepted sends on a channel with no credit returned, that channel's `can_send` goes low from the next cycle. The `can_send` bits of the other channels do not change.
- R3: A send on a channel whose `can_send` is low is discarded. Nothing is written to that channel's buffer, and its credit count stays at zero.
- R4: Each channel's buffer is first in, first out. When `deq_req` is high and `vc_ready[deq_vc]` is high at a clock edge, the cycle after that edge shows `out_valid` high, `out_vc` equal to that channel, and `out_data` equal to the oldest flit of that channel.
- R5: A dequeue request on a channel whose `vc_ready` is low has no effect. `out_valid` stays low, and no credit is produced.
- R6: A dequeue accepted at edge E puts out exactly one credit pulse. `crd_valid` is high with `crd_vc` equal to the channel during the single cycle after edge E+RET_DELAY-1. The credit is added at edge E+RET_DELAY, so `can_send` of that channel may rise only after that edge.
- R7: If a returned credit and an accepted send fall on the same channel at the same edge, that channel's count does not change.
- R8: A credit count never goes above BUF_DEPTH or below zero. For every channel, count + buffer occupancy + credits in flight always equals BUF_DEPTH.
- R9: Take a source that sends whenever `can_send` is high and a sink that dequeues every cycle. One channel then carries min(1, BUF_DEPTH/(RET_DELAY+2)) flits per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snd_valid | input | 1 | Sender offers a flit |
| snd_vc | input | VC_W | Virtual channel of the offered flit |
| snd_data | input | DATA_W | Flit payload |
| can_send | output | NUM_VC | Per-channel credit available (registered) |
| deq_req | input | 1 | Consumer asks for one flit |
| deq_vc | input | VC_W | Channel to dequeue from |
| vc_ready | output | NUM_VC | Per-channel buffer holds at least one flit |
| out_valid | output | 1 | Dequeued flit present |
| out_vc | output | VC_W | Channel of the dequeued flit |
| out_data | output | DATA_W | Dequeued payload |
| crd_valid | output | 1 | Credit arriving at the sender this cycle |
| crd_vc | output | VC_W | Channel of the arriving credit |

## Verification
The hardest case to reach from the ports is a returned credit landing on the same edge as a send on the same channel. A dequeue fixes the edge at which the credit arrives. The bench then counts RET_DELAY cycles from that dequeue and issues a send timed to meet it. Two follow-up sends then show whether the credit and the send cancelled exactly. A second instance with a single-entry buffer runs beside the default one under a saturating source and sink, and the accept counts of the two are compared with the round-trip formula.

// File: rtl/vcl_pkg.sv
package vcl_pkg;
  // Index width that never collapses to zero bits.
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/vcl_credit_tracker.sv
module vcl_credit_tracker #(
  parameter int NVC   = 2,
  parameter int DEPTH = 4,
  parameter int VCW   = 1,
  parameter int CW    = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    snd_vld,
  input  logic [VCW-1:0]          snd_vc,
  input  logic                    ret_vld,
  input  logic [VCW-1:0]          ret_vc,
  output logic                    accept,
  output logic [NVC-1:0]          can_send,
  output logic [NVC-1:0][CW-1:0]  cnt
);

  assign accept = snd_vld && can_send[snd_vc];

  for (genvar v = 0; v < NVC; v++) begin : g_vc
    logic [CW-1:0] cnt_q, cnt_n;
    logic          ok_q;
    logic          take, give;

    assign take = accept  && (snd_vc == VCW'(v));
    assign give = ret_vld && (ret_vc == VCW'(v));

    always_comb begin
      cnt_n = cnt_q;
      if (give && !take)      cnt_n = cnt_q + 1'b1;
      else if (take && !give) cnt_n = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= CW'(DEPTH);
        ok_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_n;
        ok_q  <= (cnt_n != '0);
      end
    end

    assign cnt[v]      = cnt_q;
    assign can_send[v] = ok_q;

    // R8: count stays within the buffer depth
    assert_cnt_ceiling_R8: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CW'(DEPTH));
    // R8: a returned credit never arrives on a channel already full of credit
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
      (give && !take) |-> (cnt_q != CW'(DEPTH)));
    // R3: a blocked send leaves the empty count at zero
    assert_blocked_send_R3: assert property (@(posedge clk) disable iff (rst)
      (snd_vld && snd_vc == VCW'(v) && cnt_q == '0 && !give) |=> (cnt_q == '0));
  end

endmodule

// File: rtl/vcl_vc_buffer.sv
module vcl_vc_buffer #(
  parameter int NVC   = 2,
  parameter int DEPTH = 4,
  parameter int DW    = 16,
  parameter int VCW   = 1,
  parameter int CW    = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [VCW-1:0]          wr_vc,
  input  logic [DW-1:0]           wr_data,
  input  logic                    rd_req,
  input  logic [VCW-1:0]          rd_vc,
  output logic                    pop,
  output logic [NVC-1:0]          avail,
  output logic [NVC-1:0][CW-1:0]  occ,
  output logic                    out_valid,
  output logic [VCW-1:0]          out_vc,
  output logic [DW-1:0]           out_data
);

  localparam int PW   = vcl_pkg::idx_bits(DEPTH);
  localparam int MEMD = 1 << PW;

  logic [DW-1:0] head_arr [NVC];
  logic          out_valid_q;
  logic [VCW-1:0] out_vc_q;

  assign pop = rd_req && avail[rd_vc];

  for (genvar v = 0; v < NVC; v++) begin : g_fifo
    logic [DW-1:0] mem [MEMD];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] level;
    logic [DW-1:0] head_q;
    logic          wr, rd;

    assign wr = wr_en && (wr_vc == VCW'(v));
    assign rd = pop   && (rd_vc == VCW'(v));

    // storage and registered read port, no reset
    always_ff @(posedge clk) begin
      if (wr) mem[wptr] <= wr_data;
      if (rd) head_q    <= mem[rptr];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        wptr  <= '0;
        rptr  <= '0;
        level <= '0;
      end else begin
        if (wr) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
        if (rd) rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
        if (wr && !rd)      level <= level + 1'b1;
        else if (rd && !wr) level <= level - 1'b1;
      end
    end

    assign head_arr[v] = head_q;
    assign occ[v]      = level;
    assign avail[v]    = (level != '0);

    // R8: the credit scheme keeps every buffer from overflowing
    assert_buf_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
      wr |-> (level != CW'(DEPTH)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      out_vc_q    <= '0;
    end else begin
      out_valid_q <= pop;
      if (pop) out_vc_q <= rd_vc;
    end
  end

  assign out_valid = out_valid_q;
  assign out_vc    = out_vc_q;
  assign out_data  = head_arr[out_vc_q];

  // R4: an accepted dequeue presents a flit on the following cycle
  assert_pop_output_R4: assert property (@(posedge clk) disable iff (rst)
    pop |=> out_valid);

endmodule

// File: rtl/vcl_credit_pipe.sv
module vcl_credit_pipe #(
  parameter int NVC   = 2,
  parameter int DELAY = 4,
  parameter int VCW   = 1,
  parameter int CW    = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic [VCW-1:0]          in_vc,
  output logic                    out_vld,
  output logic [VCW-1:0]          out_vc,
  output logic [NVC-1:0][CW-1:0]  pend
);

  logic [DELAY-1:0] stg_v;
  logic [VCW-1:0]   stg_c [DELAY];

  always_ff @(posedge clk) begin
    if (rst) stg_v <= '0;
    else begin
      stg_v[0] <= in_vld;
      for (int i = 1; i < DELAY; i++) stg_v[i] <= stg_v[i-1];
    end
  end

  always_ff @(posedge clk) begin
    stg_c[0] <= in_vc;
    for (int i = 1; i < DELAY; i++) stg_c[i] <= stg_c[i-1];
  end

  assign out_vld = stg_v[DELAY-1];
  assign out_vc  = stg_c[DELAY-1];

  // credits in flight per channel
  always_comb begin
    pend = '0;
    for (int i = 0; i < DELAY; i++)
      for (int v = 0; v < NVC; v++)
        if (stg_v[i] && stg_c[i] == VCW'(v)) pend[v] = pend[v] + 1'b1;
  end

endmodule

// File: rtl/vc_credit_link.sv
module vc_credit_link #(
  parameter int NUM_VC    = 2,
  parameter int BUF_DEPTH = 4,
  parameter int RET_DELAY = 4,
  parameter int DATA_W    = 16,
  localparam int VC_W     = vcl_pkg::idx_bits(NUM_VC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snd_valid,
  input  logic [VC_W-1:0]   snd_vc,
  input  logic [DATA_W-1:0] snd_data,
  output logic [NUM_VC-1:0] can_send,
  input  logic              deq_req,
  input  logic [VC_W-1:0]   deq_vc,
  output logic [NUM_VC-1:0] vc_ready,
  output logic              out_valid,
  output logic [VC_W-1:0]   out_vc,
  output logic [DATA_W-1:0] out_data,
  output logic              crd_valid,
  output logic [VC_W-1:0]   crd_vc
);

  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  logic                         accept;
  logic                         pop;
  logic [NUM_VC-1:0][CNT_W-1:0] credit_cnt;
  logic [NUM_VC-1:0][CNT_W-1:0] buf_occ;
  logic [NUM_VC-1:0][CNT_W-1:0] in_flight;

  vcl_credit_tracker #(
    .NVC(NUM_VC), .DEPTH(BUF_DEPTH), .VCW(VC_W), .CW(CNT_W)
  ) u_tracker (
    .clk(clk), .rst(rst),
    .snd_vld(snd_valid), .snd_vc(snd_vc),
    .ret_vld(crd_valid), .ret_vc(crd_vc),
    .accept(accept), .can_send(can_send), .cnt(credit_cnt)
  );

  vcl_vc_buffer #(
    .NVC(NUM_VC), .DEPTH(BUF_DEPTH), .DW(DATA_W), .VCW(VC_W), .CW(CNT_W)
  ) u_buffer (
    .clk(clk), .rst(rst),
    .wr_en(accept), .wr_vc(snd_vc), .wr_data(snd_data),
    .rd_req(deq_req), .rd_vc(deq_vc),
    .pop(pop), .avail(vc_ready), .occ(buf_occ),
    .out_valid(out_valid), .out_vc(out_vc), .out_data(out_data)
  );

  vcl_credit_pipe #(
    .NVC(NUM_VC), .DELAY(RET_DELAY), .VCW(VC_W), .CW(CNT_W)
  ) u_return (
    .clk(clk), .rst(rst),
    .in_vld(pop), .in_vc(deq_vc),
    .out_vld(crd_valid), .out_vc(crd_vc), .pend(in_flight)
  );

  for (genvar v = 0; v < NUM_VC; v++) begin : g_chk
    // R8: credits are conserved across sender, buffer and return path
    assert_credit_conserve_R8: assert property (@(posedge clk) disable iff (rst)
      (int'(credit_cnt[v]) + int'(buf_occ[v]) + int'(in_flight[v])) == BUF_DEPTH);
  end

  // R5: dequeue of an empty channel produces no output
  assert_empty_deq_R5: assert property (@(posedge clk) disable iff (rst)
    (deq_req && !vc_ready[deq_vc]) |=> !out_valid);

endmodule

// File: tb/test_vc_credit_link.sv
module test_vc_credit_link;
  localparam int NV = 2;
  localparam int DP = 4;
  localparam int DL = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          snd_valid = 0, deq_req = 0;
  logic [0:0]    snd_vc = 0, deq_vc = 0;
  logic [DW-1:0] snd_data = 0;
  logic [NV-1:0] can_send, vc_ready;
  logic          out_valid, crd_valid;
  logic [0:0]    out_vc, crd_vc;
  logic [DW-1:0] out_data;

  logic          s_snd_valid = 0, s_deq_req = 0;
  logic [NV-1:0] s_can_send, s_vc_ready;
  logic          s_out_valid, s_crd_valid;
  logic [0:0]    s_out_vc, s_crd_vc;
  logic [DW-1:0] s_out_data;

  vc_credit_link #(.NUM_VC(NV), .BUF_DEPTH(DP), .RET_DELAY(DL), .DATA_W(DW)) i_vc_credit_link (
    .clk(clk), .rst(rst), .snd_valid(snd_valid), .snd_vc(snd_vc), .snd_data(snd_data),
    .can_send(can_send), .deq_req(deq_req), .deq_vc(deq_vc), .vc_ready(vc_ready),
    .out_valid(out_valid), .out_vc(out_vc), .out_data(out_data),
    .crd_valid(crd_valid), .crd_vc(crd_vc));

  vc_credit_link #(.NUM_VC(NV), .BUF_DEPTH(1), .RET_DELAY(DL), .DATA_W(DW)) i_vc_credit_link_shallow (
    .clk(clk), .rst(rst), .snd_valid(s_snd_valid), .snd_vc(1'b0), .snd_data(16'h0),
    .can_send(s_can_send), .deq_req(s_deq_req), .deq_vc(1'b0), .vc_ready(s_vc_ready),
    .out_valid(s_out_valid), .out_vc(s_out_vc), .out_data(s_out_data),
    .crd_valid(s_crd_valid), .crd_vc(s_crd_vc));

  int tests = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] q0[$], q1[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_exp(input int vc, input logic [DW-1:0] d);
    if (vc == 0) q0.push_back(d); else q1.push_back(d);
  endtask

  // driver: flit leaves at the edge after this negedge
  task automatic drive_send(input int vc, input logic [DW-1:0] d, input bit expect_ok);
    @(negedge clk);
    snd_valid = 1; snd_vc = vc[0]; snd_data = d;
    if (expect_ok) push_exp(vc, d);
  endtask

  task automatic drive_deq(input int vc);
    @(negedge clk);
    deq_req = 1; deq_vc = vc[0];
  endtask

  // monitor: scoreboard compare of every dequeued flit (R4)
  always @(negedge clk) begin
    logic [DW-1:0] e;
    if (!rst && out_valid) begin
      if ((out_vc == 0 && q0.size() == 0) || (out_vc == 1 && q1.size() == 0))
        chk(0, "R4 unexpected flit", {16'h0, out_data}, 32'h0);
      else begin
        e = (out_vc == 0) ? q0.pop_front() : q1.pop_front();
        chk(out_data == e, "R4 order", {16'h0, out_data}, {16'h0, e});
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int acc_m, acc_s;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(can_send == 2'b11, "R1 can_send", can_send, 2'b11);
    chk(vc_ready == 2'b00, "R1 vc_ready", vc_ready, 0);
    chk(!out_valid && !crd_valid, "R1 out/crd", {out_valid, crd_valid}, 0);

    // R2 exhaust VC1
    for (int k = 0; k < DP; k++) drive_send(1, 16'h1100 + k, 1);
    @(negedge clk); snd_valid = 0;
    chk(can_send == 2'b01, "R2 exhausted", can_send, 2'b01);

    // R3 blocked send is dropped
    drive_send(1, 16'hDEAD, 0);
    @(negedge clk); snd_valid = 0;
    chk(can_send == 2'b01, "R3 still blocked", can_send, 2'b01);

    // R6 credit return timing after one dequeue
    drive_deq(1);
    @(negedge clk); deq_req = 0;
    for (int j = 0; j <= DL + 1; j++) begin
      if (j > 0) @(negedge clk);
      chk(crd_valid == (j == DL - 1), "R6 crd_valid", crd_valid, (j == DL - 1));
      if (j == DL - 1) chk(crd_vc == 1, "R6 crd_vc", crd_vc, 1);
      chk(can_send[1] == (j >= DL), "R6 can_send", can_send[1], (j >= DL));
    end

    // drain VC1, then R3 check the dropped flit is absent
    drive_deq(1); drive_deq(1); drive_deq(1);
    @(negedge clk); deq_req = 0;
    repeat (DL + 4) @(negedge clk);
    chk(vc_ready == 2'b00, "R3 nothing stored", vc_ready, 0);
    chk(can_send == 2'b11, "R2 credits restored", can_send, 2'b11);

    // R5 dequeue on empty channel
    deq_req = 1; deq_vc = 1;
    @(negedge clk); deq_req = 0;
    chk(!out_valid, "R5 no output", out_valid, 0);
    for (int j = 1; j <= DL + 1; j++) begin
      @(negedge clk);
      chk(!crd_valid, "R5 no credit", crd_valid, 0);
    end
    chk(can_send == 2'b11, "R5 counts unchanged", can_send, 2'b11);

    // R7 credit and send collide on VC0
    for (int k = 0; k < 3; k++) drive_send(0, 16'h2200 + k, 1);
    @(negedge clk); snd_valid = 0; deq_req = 1; deq_vc = 0;
    @(negedge clk); deq_req = 0;
    repeat (DL - 1) @(negedge clk);
    snd_valid = 1; snd_vc = 0; snd_data = 16'h2210; push_exp(0, 16'h2210);
    @(negedge clk);
    chk(can_send[0] == 1, "R7 count held at 1", can_send[0], 1);
    snd_data = 16'h2211; push_exp(0, 16'h2211);
    @(negedge clk); snd_valid = 0;
    chk(can_send[0] == 0, "R7 next send empties", can_send[0], 0);
    for (int k = 0; k < DP; k++) drive_deq(0);
    @(negedge clk); deq_req = 0;
    repeat (DL + 4) @(negedge clk);
    chk(can_send == 2'b11, "R8 all credits back", can_send, 2'b11);

    // R4 interleaved channels
    for (int k = 0; k < 6; k++) drive_send(k % 2, 16'h7000 + k, 1);
    @(negedge clk); snd_valid = 0;
    drive_deq(1); drive_deq(0); drive_deq(0); drive_deq(1); drive_deq(1); drive_deq(0);
    @(negedge clk); deq_req = 0;
    repeat (DL + 4) @(negedge clk);
    chk(q0.size() == 0 && q1.size() == 0, "R4 all delivered", q0.size() + q1.size(), 0);

    // R9 sustained rate, default depth vs single-entry buffer
    acc_m = 0; acc_s = 0;
    deq_req = 1; deq_vc = 0; s_deq_req = 1;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      snd_valid = can_send[0]; snd_vc = 0; snd_data = 16'h5000 + i;
      if (can_send[0]) begin
        push_exp(0, 16'h5000 + i);
        if (i >= 30) acc_m++;
      end
      s_snd_valid = s_can_send[0];
      if (s_can_send[0] && i >= 30) acc_s++;
    end
    @(negedge clk); snd_valid = 0; s_snd_valid = 0;
    repeat (DL + 10) @(negedge clk);
    deq_req = 0; s_deq_req = 0;
    chk(acc_m >= 79 && acc_m <= 81, "R9 depth 4 rate", acc_m, 80);
    chk(acc_s >= 19 && acc_s <= 21, "R9 depth 1 rate", acc_s, 20);
    repeat (4) @(negedge clk);
    chk(q0.size() == 0, "R4 stream drained", q0.size(), 0);
    chk(can_send == 2'b11, "R8 final credits", can_send, 2'b11);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule